// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a shared memory with two independent access ports, left and right. Each port runs on its own clock, and either port can read or write any word. Software-free hardware sequencers use it to hand blocks of data between two clock domains.

Each port has its own burst address counter. An access can take its address from the external address bus, and that address is then loaded into the counter. An access can instead use the counter's current value. The counter can be stepped by one or cleared, so long runs of consecutive words can be moved without driving the address bus on every cycle.

Each port's read data comes out through either one register stage (flow-through) or two register stages (pipelined), as chosen by a static select input. Read data is a plain valid-qualified stream: `rvalid` marks a result and `rdata` carries it. There is no ready input and no back-pressure. A consumer must accept every word in the cycle it is presented, and a result that is not taken is lost. Control pins are plain levels sampled on the port's rising clock edge.

The address width `AW` is a parameter. Real instances use 15, 16 or 17 bits, giving 32K, 64K or 128K words. The default is 10 bits so that elaboration stays small. The data width `DW` is 8 or 9 bits.

Top module: `dpram_burst_top`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1 at the rising edge. When a port is not selected, it writes nothing and produces no read result (`rvalid` stays 0 for that access).
- R2: When `ads_n` is 0 and `clr_n` is 1 at an edge, the access uses `addr`, and the port's counter takes the value `addr`.
- R3: When `clr_n` is 0 at an edge, the access uses word 0 and the counter becomes 0. This holds whatever `ads_n` and `step_n` are.
- R4: When `clr_n`=1, `ads_n`=1 and `step_n`=0 at an edge, the access uses the current counter value, and the counter then advances by one. It wraps from 2^AW-1 to 0.
- R5: When `clr_n`, `ads_n` and `step_n` are all 1, the access uses the current counter value and the counter keeps it.
- R6: A selected access with `rnw`=0 stores `wdata` at the access address. A later read from either port returns the most recent value written by either port.
- R7: With `pipe`=0, a selected read (`rnw`=1) captured at edge N shows `rvalid`=1 and its data after edge N.
- R8: With `pipe`=1, the same read shows its result after edge N+1 instead. Back-to-back reads yield one result per cycle.
- R9: While `oe_n` is 1, `rdata` is 0 and `rvalid` is 0. After reset, both ports show `rdata`=0 and `rvalid`=0.
- R10: The burst counter obeys R2 to R5 whether or not the port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_n_l | input | 1 | Left port asynchronous reset, active low |
| addr_l | input | AW | Left external address |
| ads_n_l | input | 1 | Left address strobe, active low |
| step_n_l | input | 1 | Left counter step enable, active low |
| clr_n_l | input | 1 | Left counter clear, active low |
| ce0_n_l | input | 1 | Left chip enable, active low |
| ce1_l | input | 1 | Left chip enable, active high |
| rnw_l | input | 1 | Left read (1) / write (0) |
| oe_n_l | input | 1 | Left output enable, active low |
| pipe_l | input | 1 | Left read path: 0 flow-through, 1 pipelined |
| wdata_l | input | DW | Left write data |
| rdata_l | output | DW | Left read data |
| rvalid_l | output | 1 | Left read data valid |
| clk_r | input | 1 | Right port clock |
| rst_n_r | input | 1 | Right port asynchronous reset, active low |
| addr_r | input | AW | Right external address |
| ads_n_r | input | 1 | Right address strobe, active low |
| step_n_r | input | 1 | Right counter step enable, active low |
| clr_n_r | input | 1 | Right counter clear, active low |
| ce0_n_r | input | 1 | Right chip enable, active low |
| ce1_r | input | 1 | Right chip enable, active high |
| rnw_r | input | 1 | Right read (1) / write (0) |
| oe_n_r | input | 1 | Right output enable, active low |
| pipe_r | input | 1 | Right read path: 0 flow-through, 1 pipelined |
| wdata_r | input | DW | Right write data |
| rdata_r | output | DW | Right read data |
| rvalid_r | output | 1 | Right read data valid |

## Verification
A read driven before edge N is due one edge later in flow-through mode and two edges later in pipelined mode. Writes and counter moves take effect at edge N and are seen through later reads. The driver stamps every access with its due cycle, counted in that port's own clock, and pushes the stamp into that port's queue. The monitor samples on the falling edge and compares only the item whose stamp matches the current cycle, so a result that comes early or late shows up as a mismatch or a missed item. The mode is switched only after idle cycles, so no access is in flight when the latency changes.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } acc_kind_t;

  function automatic acc_kind_t decode_kind(input logic ce0_n, input logic ce1, input logic rnw);
    acc_kind_t k;
    k.sel = ~ce0_n & ce1;
    k.wr  = k.sel & ~rnw;
    k.rd  = k.sel & rnw;
    return k;
  endfunction
endpackage

// File: rtl/dpram_addr_ctr.sv
`timescale 1ns/1ps
module dpram_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ads_n,
  input  logic          step_n,
  input  logic          clr_n,
  output logic [AW-1:0] acc_addr
);
  logic [AW-1:0] cnt;

  always_comb begin
    if (!clr_n)      acc_addr = '0;
    else if (!ads_n) acc_addr = addr;
    else             acc_addr = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!clr_n)  cnt <= '0;
    else if (!ads_n)  cnt <= addr;
    else if (!step_n) cnt <= cnt + AW'(1);
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> cnt == '0); // R3
  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ads_n) |=> cnt == $past(addr)); // R2
  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ads_n && !step_n) |=> cnt == $past(cnt) + AW'(1)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ads_n && step_n) |=> $stable(cnt)); // R5
endmodule

// File: rtl/dpram_bank.sv
`timescale 1ns/1ps
module dpram_bank #(
  parameter int AW      = 10,
  parameter int DW      = 9,
  parameter bit INV_TAG = 1'b0
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic                tag_other,
  input  logic [1:0][AW-1:0]  raddr,
  output logic [1:0][DW-1:0]  rdata,
  output logic [1:0]          rtag
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          tag [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
      tag[waddr] <= tag_other ^ INV_TAG;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_rd
    assign rdata[k] = mem[raddr[k]];
    assign rtag[k]  = tag[raddr[k]];
  end
endmodule

// File: rtl/dpram_rd_stage.sv
`timescale 1ns/1ps
module dpram_rd_stage
  import dpram_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  rd_mode_e      mode,
  input  logic [DW-1:0] word_in,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          s1_v, s2_v;
  logic [DW-1:0] s1_d, s2_d;
  logic          out_v;
  logic [DW-1:0] out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_d <= '0;
      s2_v <= 1'b0;
      s2_d <= '0;
    end else begin
      s1_v <= rd_en;
      if (rd_en) s1_d <= word_in;
      s2_v <= s1_v;
      s2_d <= s1_d;
    end
  end

  always_comb begin
    if (mode == RD_PIPE) begin
      out_v = s2_v;
      out_d = s2_d;
    end else begin
      out_v = s1_v;
      out_d = s1_d;
    end
  end

  assign rvalid = out_v & ~oe_n;
  assign rdata  = oe_n ? '0 : out_d;

  AST_READ_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> s1_v); // R7
  AST_NO_READ_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !s1_v); // R1
  AST_PIPE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> (s2_v && s2_d == $past(s1_d))); // R8
endmodule

// File: rtl/dpram_burst_top.sv
`timescale 1ns/1ps
module dpram_burst_top
  import dpram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk_l,
  input  logic          rst_n_l,
  input  logic [AW-1:0] addr_l,
  input  logic          ads_n_l,
  input  logic          step_n_l,
  input  logic          clr_n_l,
  input  logic          ce0_n_l,
  input  logic          ce1_l,
  input  logic          rnw_l,
  input  logic          oe_n_l,
  input  logic          pipe_l,
  input  logic [DW-1:0] wdata_l,
  output logic [DW-1:0] rdata_l,
  output logic          rvalid_l,
  input  logic          clk_r,
  input  logic          rst_n_r,
  input  logic [AW-1:0] addr_r,
  input  logic          ads_n_r,
  input  logic          step_n_r,
  input  logic          clr_n_r,
  input  logic          ce0_n_r,
  input  logic          ce1_r,
  input  logic          rnw_r,
  input  logic          oe_n_r,
  input  logic          pipe_r,
  input  logic [DW-1:0] wdata_r,
  output logic [DW-1:0] rdata_r,
  output logic          rvalid_r
);
  localparam int NP = 2;

  logic [NP-1:0]               clk_a, rst_a, ads_a, step_a, clr_a;
  logic [NP-1:0]               ce0_a, ce1_a, rnw_a, oe_a, pipe_a;
  logic [NP-1:0][AW-1:0]       addr_a, acc_a;
  logic [NP-1:0][DW-1:0]       wdata_a, rdata_a, word_a;
  logic [NP-1:0]               rvalid_a;
  acc_kind_t [NP-1:0]          kind_a;
  logic [NP-1:0][NP-1:0][DW-1:0] bdata;
  logic [NP-1:0][NP-1:0]       btag;

  assign clk_a   = {clk_r, clk_l};
  assign rst_a   = {rst_n_r, rst_n_l};
  assign addr_a  = {addr_r, addr_l};
  assign ads_a   = {ads_n_r, ads_n_l};
  assign step_a  = {step_n_r, step_n_l};
  assign clr_a   = {clr_n_r, clr_n_l};
  assign ce0_a   = {ce0_n_r, ce0_n_l};
  assign ce1_a   = {ce1_r, ce1_l};
  assign rnw_a   = {rnw_r, rnw_l};
  assign oe_a    = {oe_n_r, oe_n_l};
  assign pipe_a  = {pipe_r, pipe_l};
  assign wdata_a = {wdata_r, wdata_l};

  assign rdata_l  = rdata_a[0];
  assign rvalid_l = rvalid_a[0];
  assign rdata_r  = rdata_a[1];
  assign rvalid_r = rvalid_a[1];

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign kind_a[i] = decode_kind(ce0_a[i], ce1_a[i], rnw_a[i]);

    dpram_addr_ctr #(.AW(AW)) u_ctr (
      .clk      (clk_a[i]),
      .rst_n    (rst_a[i]),
      .addr     (addr_a[i]),
      .ads_n    (ads_a[i]),
      .step_n   (step_a[i]),
      .clr_n    (clr_a[i]),
      .acc_addr (acc_a[i])
    );

    dpram_bank #(.AW(AW), .DW(DW), .INV_TAG(i == 1)) u_bank (
      .clk       (clk_a[i]),
      .we        (kind_a[i].wr),
      .waddr     (acc_a[i]),
      .wdata     (wdata_a[i]),
      .tag_other (btag[NP-1-i][i]),
      .raddr     (acc_a),
      .rdata     (bdata[i]),
      .rtag      (btag[i])
    );

    assign word_a[i] = (btag[0][i] ^ btag[1][i]) ? bdata[1][i] : bdata[0][i];

    dpram_rd_stage #(.DW(DW)) u_rd (
      .clk     (clk_a[i]),
      .rst_n   (rst_a[i]),
      .rd_en   (kind_a[i].rd),
      .mode    (rd_mode_e'(pipe_a[i])),
      .word_in (word_a[i]),
      .oe_n    (oe_a[i]),
      .rdata   (rdata_a[i]),
      .rvalid  (rvalid_a[i])
    );
  end

  AST_LEFT_FLOW_RESULT: assert property (@(posedge clk_l) disable iff (!rst_n_l)
    (!ce0_n_l && ce1_l && rnw_l && !pipe_l && !oe_n_l) |=>
      (pipe_l || oe_n_l || rvalid_l)); // R7
  AST_LEFT_DESEL_QUIET: assert property (@(posedge clk_l) disable iff (!rst_n_l)
    ((ce0_n_l || !ce1_l) && !pipe_l) |=> (pipe_l || !rvalid_l)); // R1
endmodule

// File: tb/sim_dpram_burst_top.sv
`timescale 1ns/1ps
module sim_dpram_burst_top;
  localparam int AW = 10;
  localparam int DW = 9;

  typedef struct {
    int            due;
    bit            v;
    logic [DW-1:0] d;
    string         req;
  } exp_t;

  logic clk_l = 1'b0, clk_r = 1'b0;
  logic rst_n_l, rst_n_r;
  logic [AW-1:0] addr [2];
  logic ads_n [2], step_n [2], clr_n [2], ce0_n [2], ce1 [2], rnw [2], oe_n [2], pipe [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata_l, rdata_r;
  logic rvalid_l, rvalid_r;

  exp_t q0[$], q1[$];
  int cyc [2];
  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] cnt_m [2];
  logic [DW-1:0] mem_m [int];

  always #10 clk_l = ~clk_l;
  initial begin
    #7;
    forever #10 clk_r = ~clk_r;
  end

  dpram_burst_top #(.AW(AW), .DW(DW)) u0 (
    .clk_l(clk_l), .rst_n_l(rst_n_l), .addr_l(addr[0]), .ads_n_l(ads_n[0]),
    .step_n_l(step_n[0]), .clr_n_l(clr_n[0]), .ce0_n_l(ce0_n[0]), .ce1_l(ce1[0]),
    .rnw_l(rnw[0]), .oe_n_l(oe_n[0]), .pipe_l(pipe[0]), .wdata_l(wdata[0]),
    .rdata_l(rdata_l), .rvalid_l(rvalid_l),
    .clk_r(clk_r), .rst_n_r(rst_n_r), .addr_r(addr[1]), .ads_n_r(ads_n[1]),
    .step_n_r(step_n[1]), .clr_n_r(clr_n[1]), .ce0_n_r(ce0_n[1]), .ce1_r(ce1[1]),
    .rnw_r(rnw[1]), .oe_n_r(oe_n[1]), .pipe_r(pipe[1]), .wdata_r(wdata[1]),
    .rdata_r(rdata_r), .rvalid_r(rvalid_r)
  );

  always @(posedge clk_l) cyc[0] <= cyc[0] + 1;
  always @(posedge clk_r) cyc[1] <= cyc[1] + 1;

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_neg(input int p);
    if (p == 0) @(negedge clk_l);
    else        @(negedge clk_r);
  endtask

  task automatic mon(ref exp_t q[$], input int c, input logic v, input logic [DW-1:0] d);
    exp_t e;
    while (q.size() > 0 && q[0].due < c) begin
      e = q.pop_front();
      chk(1'b0, {e.req, " missed"}, '0, {e.v, e.d});
    end
    if (q.size() > 0 && q[0].due == c) begin
      e = q.pop_front();
      if (e.v) chk(v === 1'b1 && d === e.d, e.req, {v, d}, {1'b1, e.d});
      else     chk(v === 1'b0, e.req, {v, d}, {1'b0, d});
    end
  endtask

  always @(negedge clk_l) mon(q0, cyc[0], rvalid_l, rdata_l);
  always @(negedge clk_r) mon(q1, cyc[1], rvalid_r, rdata_r);

  task automatic idle(input int p);
    wait_neg(p);
    ce0_n[p] = 1'b1; ce1[p] = 1'b0; ads_n[p] = 1'b1; step_n[p] = 1'b1;
    clr_n[p] = 1'b1; rnw[p] = 1'b1;
  endtask

  // Model of the access rules: clear > strobe > step > hold, access at the pre-edge counter
  task automatic drive(input int p, input bit c0n, input bit c1, input bit adsn, input bit stpn,
                       input bit clrn, input bit rw, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string req);
    logic [AW-1:0] acc;
    bit sel;
    exp_t e;
    wait_neg(p);
    ce0_n[p] = c0n; ce1[p] = c1; ads_n[p] = adsn; step_n[p] = stpn; clr_n[p] = clrn;
    rnw[p] = rw; addr[p] = a; wdata[p] = d;
    sel = !c0n && c1;
    if (!clrn)      acc = '0;
    else if (!adsn) acc = a;
    else            acc = cnt_m[p];
    if (!clrn)      cnt_m[p] = '0;
    else if (!adsn) cnt_m[p] = a;
    else if (!stpn) cnt_m[p] = cnt_m[p] + AW'(1);
    e.due = cyc[p] + 1 + (pipe[p] ? 1 : 0);
    e.req = req;
    e.v   = sel && rw && !oe_n[p];
    e.d   = mem_m.exists(int'(acc)) ? mem_m[int'(acc)] : '0;
    if (sel && !rw) mem_m[int'(acc)] = d;
    if (p == 0) q0.push_back(e);
    else        q1.push_back(e);
  endtask

  // shorthands: selected write / read through the external address
  task automatic wr_at(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    drive(p, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, a, d, req);
  endtask
  task automatic rd_at(input int p, input logic [AW-1:0] a, input string req);
    drive(p, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, a, '0, req);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_l);
    chk(1'b0, "watchdog", '0, '1);
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      ce0_n[p] = 1'b1; ce1[p] = 1'b0; ads_n[p] = 1'b1; step_n[p] = 1'b1; clr_n[p] = 1'b1;
      rnw[p] = 1'b1; oe_n[p] = 1'b0; pipe[p] = 1'b0; addr[p] = '0; wdata[p] = '0;
      cnt_m[p] = '0;
    end
    rst_n_l = 1'b0; rst_n_r = 1'b0;
    #55;
    rst_n_l = 1'b1; rst_n_r = 1'b1;
    wait_neg(0);
    chk(rvalid_l === 1'b0 && rdata_l === '0, "R9 reset left", {rvalid_l, rdata_l}, '0);
    chk(rvalid_r === 1'b0 && rdata_r === '0, "R9 reset right", {rvalid_r, rdata_r}, '0);

    // R3: clear writes word 0 even with an address present
    drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd55, 9'h011, "R3");
    // R5: hold reads the counter (0) twice
    drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, '0, "R5 hold");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, '0, "R5 hold again");

    // R2: strobed writes and reads
    wr_at(0, 10'd100, 9'h0A5, "R2");
    wr_at(0, 10'd101, 9'h05A, "R2");
    rd_at(0, 10'd100, "R2 read 100");
    rd_at(0, 10'd101, "R2 read 101");

    // R4: burst with steps
    wr_at(0, 10'd200, 9'h001, "R4");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 9'h002, "R4");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 9'h003, "R4");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 9'h004, "R4");
    rd_at(0, 10'd200, "R4 read 200");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0, '0, "R4 step read 200");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0, '0, "R4 step read 201");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0, '0, "R4 step read 202");

    // R3 priority over strobe and step
    drive(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd100, '0, "R3 clear wins");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd100, '0, "R3 counter at 0");

    // R1: deselected writes and reads
    drive(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd100, 9'h0FF, "R1 ce1 low");
    drive(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd101, 9'h0FF, "R1 ce0 high");
    drive(0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd100, '0, "R1 deselected read");
    rd_at(0, 10'd100, "R1 word 100 kept");
    rd_at(0, 10'd101, "R1 word 101 kept");

    // R10: counter loads while deselected, then a selected hold write uses it
    drive(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd300, 9'h0EE, "R10 load");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 10'd0, 9'h033, "R10 write");
    idle(0);
    rd_at(1, 10'd300, "R10 read 300 on right");

    // R8: pipelined back-to-back reads
    idle(0); idle(0);
    pipe[0] = 1'b1;
    idle(0); idle(0);
    rd_at(0, 10'd100, "R8 pipe 100");
    rd_at(0, 10'd101, "R8 pipe 101");
    rd_at(0, 10'd200, "R8 pipe 200");
    rd_at(0, 10'd201, "R8 pipe 201");
    idle(0); idle(0); idle(0);
    pipe[0] = 1'b0;
    idle(0); idle(0);

    // R6: cross-port writes and reads, last writer wins
    wr_at(1, 10'd400, 9'h1C3, "R6");
    wr_at(1, 10'd100, 9'h0F0, "R6");
    idle(1);
    rd_at(0, 10'd400, "R6 left sees right 400");
    rd_at(0, 10'd100, "R6 left sees right 100");
    wr_at(0, 10'd100, 9'h155, "R6");
    idle(0);
    pipe[1] = 1'b1;
    idle(1); idle(1);
    rd_at(1, 10'd100, "R6 right sees left 100");
    rd_at(1, 10'd202, "R6 right sees left 202");
    idle(1); idle(1); idle(1);

    // R4 wrap from the top word to 0
    wr_at(0, 10'd1023, 9'h101, "R4 wrap");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 9'h102, "R4 wrap");
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 9'h103, "R4 wrap");
    idle(0);
    rd_at(1, 10'd1023, "R4 top word");
    rd_at(1, 10'd0, "R4 wrapped to 0");
    idle(1); idle(1); idle(1);

    // R9: output enable high blocks data
    idle(0);
    oe_n[0] = 1'b1;
    rd_at(0, 10'd400, "R9 oe high");
    wait_neg(0);
    chk(rvalid_l === 1'b0 && rdata_l === '0, "R9 oe high outputs", {rvalid_l, rdata_l}, '0);
    ce0_n[0] = 1'b1; ce1[0] = 1'b0;
    idle(0);
    oe_n[0] = 1'b0;
    rd_at(0, 10'd400, "R7 flow read after oe");

    repeat (4) begin
      idle(0);
      idle(1);
    end
    chk(q0.size() == 0 && q1.size() == 0, "all results drained", 10'(q0.size() + q1.size()), '0);
    summary();
    $finish;
  end
endmodule